// File: doc/BRIEF.md
# Beacon-Gated TDMA Transmit Slot Gate

This block decides when one transmit data queue may begin a frame in a time-division scheme. A free-running microsecond time base is compared, at full 32-bit width, with a programmed next target beacon transmission time (TBTT). When the time base reaches that value, a burst window opens. While the window is open the queue may start a frame. When the window's ready time has elapsed, no new frame may begin. A frame that is already on the air is not cut off. It finishes when the transmitter reports it done.

Each firing moves the next TBTT forward by one beacon interval, wrapping modulo 2^32. A TBTT that software programmed into the past therefore opens a single window. The TBTT then steps forward one interval per cycle until it is ahead of the time base, and the window is not re-triggered while that happens. The burst length and start time are captured when the window opens, so reprogramming while a window is open does not change the current burst. A strict-mode input decides whether the queue is held to the window at all. With strict mode off, the gate passes requests through, but it still serialises frames.

Top module: `tdma_slot_gate`

## Requirements
- R1: After reset, windowOpen, startGrant and txBusy are 0 and tbttNext is 0. No window opens until the first tbttLoad, even if the time base is past tbttNext.
- R2: Once loaded, the window opens at the clock edge where (timeNow - tbttNext), taken as a signed 32-bit value, is zero or positive. All 32 bits take part, so a time base that matches tbttNext only in its low 16 bits does not open it.
- R3: An open window closes at the first edge where timeNow minus the time base captured at opening is at least the burstLen captured at opening. So with a time base advancing one per cycle it stays open for burstLen edges.
- R4: Every firing adds beaconIntv to tbttNext modulo 2^32, so a TBTT near 2^32 wraps to a small value and fires again there.
- R5: With strictMode = 1, startGrant is 1 exactly when startReq is 1, windowOpen is 1 and txBusy is 0. Outside the window no frame starts.
- R6: With strictMode = 0, startGrant is 1 whenever startReq is 1 and txBusy is 0, whatever the window state.
- R7: A grant sets txBusy at the next edge. txBusy stays 1, also across the window closing, until an edge with frameDone = 1. No grant is given while txBusy is 1, so only one frame is started at a time.
- R8: A tbttNext that is already behind the time base opens exactly one window. While that window is open, each further due TBTT only advances tbttNext by one interval. It neither extends nor reopens the window.
- R9: tbttLoad takes priority over advancing: tbttNext equals tbttValue after the edge, and no firing happens on a load edge. Loading a new TBTT or changing burstLen while a window is open neither shortens nor lengthens that window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| timeNow | input | 32 | Free-running time base in microseconds |
| tbttLoad | input | 1 | Write tbttValue into the next-TBTT register |
| tbttValue | input | 32 | Next-TBTT value to load, in microseconds |
| beaconIntv | input | 24 | Beacon interval in microseconds |
| burstLen | input | 16 | Ready time of the burst window in microseconds |
| strictMode | input | 1 | 1: frames may start only inside the window |
| startReq | input | 1 | Queue requests to start a frame |
| frameDone | input | 1 | Frame in flight has completed |
| startGrant | output | 1 | Frame may start in this cycle |
| windowOpen | output | 1 | Burst window is open |
| txBusy | output | 1 | A granted frame is still in flight |
| tbttNext | output | 32 | Current next-TBTT value |

## Verification
The hardest situation to reach is a next TBTT that has fallen several intervals behind the time base while the window is open, together with reprogramming during that same window. The bench reaches it by driving the time base directly rather than counting it up. It loads a TBTT about 130 ms in the past and then moves the time base by single microseconds, so tbttNext can be watched stepping one interval per edge while the window stays up. Still inside that window, it changes burstLen and loads a new TBTT, then confirms that the close comes exactly at the originally captured length. Jumping the time base near 2^32 in the same way exposes the wrap of both the TBTT and the burst measurement.

// File: rtl/tdma_gate_pkg.sv
package tdma_gate_pkg;

  // Strobes issued by the control unit to the datapath each cycle
  typedef struct packed {
    logic loadTbtt;     // take the software value into next-TBTT
    logic advanceTbtt;  // a TBTT was consumed: step by one interval
    logic captureOpen;  // window opens: capture time stamp and length
  } gateStrobe_t;

  typedef enum logic [1:0] {
    GATE_UNARMED = 2'd0,
    GATE_CLOSED  = 2'd1,
    GATE_OPEN    = 2'd2
  } gateState_t;

endpackage

// File: rtl/tdma_gate_dp.sv
module tdma_gate_dp
  import tdma_gate_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int INTV_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  gateStrobe_t       strobe,
  input  logic [TIME_W-1:0] timeNow,
  input  logic [TIME_W-1:0] tbttValue,
  input  logic [INTV_W-1:0] beaconIntv,
  input  logic [LEN_W-1:0]  burstLen,
  output logic              tbttDue,
  output logic              burstExpired,
  output logic [TIME_W-1:0] tbttNext
);

  localparam int INTV_PAD = TIME_W - INTV_W;
  localparam int LEN_PAD  = TIME_W - LEN_W;

  logic [TIME_W-1:0] openStamp;
  logic [LEN_W-1:0]  lenHeld;
  logic [TIME_W-1:0] tbttDelta;
  logic [TIME_W-1:0] elapsed;

  // Modulo difference: the sign bit tells past from future
  always_comb begin
    tbttDelta    = timeNow - tbttNext;
    tbttDue      = ~tbttDelta[TIME_W-1];
    elapsed      = timeNow - openStamp;
    burstExpired = (elapsed >= {{LEN_PAD{1'b0}}, lenHeld});
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tbttNext <= '0;
    end else if (strobe.loadTbtt) begin
      tbttNext <= tbttValue;
    end else if (strobe.advanceTbtt) begin
      tbttNext <= tbttNext + {{INTV_PAD{1'b0}}, beaconIntv};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      openStamp <= '0;
      lenHeld   <= '0;
    end else if (strobe.captureOpen) begin
      openStamp <= timeNow;
      lenHeld   <= burstLen;
    end
  end

endmodule

// File: rtl/tdma_gate_ctrl.sv
module tdma_gate_ctrl
  import tdma_gate_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tbttLoad,
  input  logic        tbttDue,
  input  logic        burstExpired,
  input  logic        strictMode,
  input  logic        startReq,
  input  logic        frameDone,
  output gateStrobe_t strobe,
  output logic        startGrant,
  output logic        windowOpen,
  output logic        txBusy
);

  gateState_t state;
  gateState_t stateNext;
  logic       fireNow;
  logic       inFlight;

  always_comb begin
    fireNow            = (state != GATE_UNARMED) && tbttDue && !tbttLoad;
    strobe.loadTbtt    = tbttLoad;
    strobe.advanceTbtt = fireNow;
    strobe.captureOpen = fireNow && (state == GATE_CLOSED);
  end

  always_comb begin
    stateNext = state;
    case (state)
      GATE_UNARMED: if (tbttLoad) stateNext = GATE_CLOSED;
      GATE_CLOSED:  if (strobe.captureOpen) stateNext = GATE_OPEN;
      GATE_OPEN:    if (burstExpired) stateNext = GATE_CLOSED;
      default:      stateNext = GATE_UNARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= GATE_UNARMED;
    else       state <= stateNext;
  end

  assign windowOpen = (state == GATE_OPEN);
  assign startGrant = startReq && !inFlight && (windowOpen || !strictMode);

  always_ff @(posedge clk) begin
    if (!rstN)          inFlight <= 1'b0;
    else if (frameDone) inFlight <= 1'b0;
    else if (startGrant) inFlight <= 1'b1;
  end

  assign txBusy = inFlight;

endmodule

// File: rtl/tdma_slot_gate.sv
module tdma_slot_gate
  import tdma_gate_pkg::*;
#(
  parameter int TIME_W = 32,
  parameter int INTV_W = 24,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] timeNow,
  input  logic              tbttLoad,
  input  logic [TIME_W-1:0] tbttValue,
  input  logic [INTV_W-1:0] beaconIntv,
  input  logic [LEN_W-1:0]  burstLen,
  input  logic              strictMode,
  input  logic              startReq,
  input  logic              frameDone,
  output logic              startGrant,
  output logic              windowOpen,
  output logic              txBusy,
  output logic [TIME_W-1:0] tbttNext
);

  gateStrobe_t strobe;
  logic        tbttDue;
  logic        burstExpired;

  tdma_gate_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .tbttLoad     (tbttLoad),
    .tbttDue      (tbttDue),
    .burstExpired (burstExpired),
    .strictMode   (strictMode),
    .startReq     (startReq),
    .frameDone    (frameDone),
    .strobe       (strobe),
    .startGrant   (startGrant),
    .windowOpen   (windowOpen),
    .txBusy       (txBusy)
  );

  tdma_gate_dp #(
    .TIME_W (TIME_W),
    .INTV_W (INTV_W),
    .LEN_W  (LEN_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .timeNow      (timeNow),
    .tbttValue    (tbttValue),
    .beaconIntv   (beaconIntv),
    .burstLen     (burstLen),
    .tbttDue      (tbttDue),
    .burstExpired (burstExpired),
    .tbttNext     (tbttNext)
  );

endmodule

// File: rtl/tdma_slot_gate_chk.sv
module tdma_slot_gate_chk #(
  parameter int TIME_W = 32,
  parameter int INTV_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              strictMode,
  input logic              windowOpen,
  input logic              startGrant,
  input logic              txBusy,
  input logic              frameDone,
  input logic              tbttLoad,
  input logic [TIME_W-1:0] tbttValue,
  input logic [TIME_W-1:0] tbttNext,
  input logic [INTV_W-1:0] beaconIntv
);

  localparam int INTV_PAD = TIME_W - INTV_W;

  a_r5_no_start_outside: assert property (@(posedge clk) disable iff (!rstN)
    (strictMode && !windowOpen) |-> !startGrant);

  a_r7_one_frame: assert property (@(posedge clk) disable iff (!rstN)
    txBusy |-> !startGrant);

  a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && !frameDone) |=> txBusy);

  a_r4_step_on_open: assert property (@(posedge clk) disable iff (!rstN)
    $rose(windowOpen) |->
      (tbttNext == $past(tbttNext) + {{INTV_PAD{1'b0}}, $past(beaconIntv)}));

  a_r9_load_wins: assert property (@(posedge clk) disable iff (!rstN)
    tbttLoad |=> (tbttNext == $past(tbttValue)));

endmodule

bind tdma_slot_gate tdma_slot_gate_chk #(
  .TIME_W (TIME_W),
  .INTV_W (INTV_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .strictMode (strictMode),
  .windowOpen (windowOpen),
  .startGrant (startGrant),
  .txBusy     (txBusy),
  .frameDone  (frameDone),
  .tbttLoad   (tbttLoad),
  .tbttValue  (tbttValue),
  .tbttNext   (tbttNext),
  .beaconIntv (beaconIntv)
);

// File: tb/sim_tdma_slot_gate.sv
module sim_tdma_slot_gate;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] timeNow = '0;
  logic        tbttLoad = 1'b0;
  logic [31:0] tbttValue = '0;
  logic [23:0] beaconIntv = 24'd49152;
  logic [15:0] burstLen = 16'd2500;
  logic        strictMode = 1'b1;
  logic        startReq = 1'b0;
  logic        frameDone = 1'b0;
  logic        startGrant;
  logic        windowOpen;
  logic        txBusy;
  logic [31:0] tbttNext;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;
  logic grantSeen;

  always #10 clk = ~clk;

  tdma_slot_gate u0 (
    .clk(clk), .rstN(rstN), .timeNow(timeNow), .tbttLoad(tbttLoad),
    .tbttValue(tbttValue), .beaconIntv(beaconIntv), .burstLen(burstLen),
    .strictMode(strictMode), .startReq(startReq), .frameDone(frameDone),
    .startGrant(startGrant), .windowOpen(windowOpen), .txBusy(txBusy),
    .tbttNext(tbttNext)
  );

  // Row: time, req, done, expected grant (before edge), open, busy (after edge)
  localparam logic [36:0] VEC [13] = '{
    {32'd99999,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 closed, strict
    {32'd100000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},  // R2 opens at TBTT
    {32'd100001, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R5 grant in window
    {32'd100002, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},  // R7 busy blocks
    {32'd100003, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},  // R7 done clears
    {32'd102499, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1},  // R3 still open at len-1
    {32'd102500, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},  // R3 closes, R7 frame lives
    {32'd102600, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // R7 still busy
    {32'd102700, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // R7 done after close
    {32'd102800, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 closed blocks
    {32'd149151, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},  // R4 not yet
    {32'd149152, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},  // R4 next TBTT fires
    {32'd149153, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}   // R5 grant again
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] t, input logic req, input logic done);
    @(negedge clk);
    timeNow   = t;
    startReq  = req;
    frameDone = done;
    #1 grantSeen = startGrant;
    @(posedge clk);
    #1;
    tbttLoad  = 1'b0;
    startReq  = 1'b0;
    frameDone = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 open after reset", {31'd0, windowOpen}, 32'd0);
    check("R1 busy after reset", {31'd0, txBusy}, 32'd0);
    check("R1 tbtt after reset", tbttNext, 32'd0);
    @(negedge clk) rstN = 1'b1;
    step(32'd5000, 1'b0, 1'b0);
    check("R1 no fire before load", {31'd0, windowOpen}, 32'd0);

    tbttLoad = 1'b1; tbttValue = 32'd100000;
    step(32'd90000, 1'b0, 1'b0);
    check("R9 load value", tbttNext, 32'd100000);

    for (int i = 0; i < 13; i++) begin
      step(VEC[i][36:5], VEC[i][4], VEC[i][3]);
      check($sformatf("R5 grant row %0d", i), {31'd0, grantSeen}, {31'd0, VEC[i][2]});
      check($sformatf("R2 R3 open row %0d", i), {31'd0, windowOpen}, {31'd0, VEC[i][1]});
      check($sformatf("R7 busy row %0d", i), {31'd0, txBusy}, {31'd0, VEC[i][0]});
      if (i == 9) check("R4 advanced", tbttNext, 32'd149152);
    end

    // R6: non-strict passes requests outside the window
    strictMode = 1'b0;
    step(32'd152000, 1'b0, 1'b1);
    check("R3 closed after burst", {31'd0, windowOpen}, 32'd0);
    step(32'd153000, 1'b1, 1'b0);
    check("R6 grant while closed", {31'd0, grantSeen}, 32'd1);
    step(32'd153100, 1'b0, 1'b1);
    strictMode = 1'b1;

    // R2: full 32-bit compare, low 16 bits alone do not fire
    tbttLoad = 1'b1; tbttValue = 32'h0005_0000;
    step(32'h0003_FFFF, 1'b0, 1'b0);
    check("R9 no fire on load edge", {31'd0, windowOpen}, 32'd0);
    step(32'h0004_0000, 1'b0, 1'b0);
    check("R2 low-16 match ignored", {31'd0, windowOpen}, 32'd0);
    step(32'h0005_0000, 1'b0, 1'b0);
    check("R2 full match opens", {31'd0, windowOpen}, 32'd1);
    step(32'd330180, 1'b0, 1'b0);
    check("R3 closed", {31'd0, windowOpen}, 32'd0);

    // R8: stale TBTT fires once and catches up
    tbttLoad = 1'b1; tbttValue = 32'd200000;
    step(32'd330190, 1'b0, 1'b0);
    step(32'd330191, 1'b0, 1'b0);
    check("R8 stale opens", {31'd0, windowOpen}, 32'd1);
    check("R8 first step", tbttNext, 32'd249152);
    step(32'd330192, 1'b0, 1'b0);
    step(32'd330193, 1'b0, 1'b0);
    step(32'd330194, 1'b0, 1'b0);
    check("R8 caught up", tbttNext, 32'd347456);
    check("R8 still one window", {31'd0, windowOpen}, 32'd1);

    // R9: reprogramming inside the window leaves it alone
    burstLen = 16'd10;
    tbttLoad = 1'b1; tbttValue = 32'd999999;
    step(32'd330195, 1'b0, 1'b0);
    step(32'd332690, 1'b0, 1'b0);
    check("R9 window kept length", {31'd0, windowOpen}, 32'd1);
    step(32'd332691, 1'b0, 1'b0);
    check("R9 closes on held length", {31'd0, windowOpen}, 32'd0);
    step(32'd332692, 1'b0, 1'b0);
    check("R8 no reopen", {31'd0, windowOpen}, 32'd0);
    check("R9 loaded tbtt", tbttNext, 32'd999999);
    burstLen = 16'd2500;

    // R4: wrap across 2^32
    tbttLoad = 1'b1; tbttValue = 32'hFFFF_FF00;
    step(32'hFFFF_FE00, 1'b0, 1'b0);
    step(32'hFFFF_FF00, 1'b0, 1'b0);
    check("R4 wrap open", {31'd0, windowOpen}, 32'd1);
    check("R4 wrapped tbtt", tbttNext, 32'h0000_BF00);
    step(32'h0000_08C3, 1'b0, 1'b0);
    check("R3 open across wrap", {31'd0, windowOpen}, 32'd1);
    step(32'h0000_08C4, 1'b0, 1'b0);
    check("R3 close across wrap", {31'd0, windowOpen}, 32'd0);
    step(32'h0000_BEFF, 1'b0, 1'b0);
    check("R4 before wrapped tbtt", {31'd0, windowOpen}, 32'd0);
    step(32'h0000_BF00, 1'b0, 1'b0);
    check("R4 fires after wrap", {31'd0, windowOpen}, 32'd1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule